// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out how each of two address straps is wired on the board. A strap may be tied low, tied high, tied to the serial clock line or tied to the serial data line. The block watches every bus transaction from START to STOP. During that window it compares the sampled strap level with the clock and data levels. When the transaction closes, it decides which of the four connections each strap has. The result drives two outputs: the low nibble of the device's bus address, and the default drive levels for eight output ports, which are set in two groups of four.

The block is fed by a bus front end that supplies synchronized levels for both bus lines and both straps, plus one-cycle START and STOP strobes. Every transaction on the bus refreshes the decode, whichever device it addresses. A strap that is rewired while powered is therefore picked up at the next STOP. Between STOPs the decode never moves, so address matching stays steady inside a transaction.

Top module: `addr_pin_decoder`

## Requirements
- R1: In every cycle with `rst` high, each strap is classed from its present level alone: high gives the supply class, low gives the ground class. A strap on an idle bus line therefore reads as supply. Until the first STOP that closes a transaction, no strap can hold a bus-line class.
- R2: `addr_nibble[3:2]` encodes the class of strap `ad2_lvl` as: clock line 00, data line 01, ground 10, supply 11.
- R3: `addr_nibble[1:0]` encodes the class of strap `ad0_lvl` as: ground 00, supply 01, clock line 10, data line 11.
- R4: `port_default[7:4]` is all zeros when the `ad2_lvl` strap is classed as ground, and all ones otherwise. `port_default[3:0]` follows the same rule for the `ad0_lvl` strap.
- R5: A strap that equals the clock line in every sampled cycle of a transaction (START cycle through STOP cycle), and differs from the data line at least once, is classed as clock line once that STOP is taken.
- R6: A strap that equals the data line in every sampled cycle of a transaction, and differs from the clock line at least once, is classed as data line once that STOP is taken.
- R7: A strap that differs from both bus lines during a transaction is classed from its level: only ever high gives supply, only ever low gives ground. A strap that was both high and low keeps its previous class.
- R8: A strap that never differs from either bus line during a transaction keeps its previous class.
- R9: Classes, and therefore both outputs, change only in the cycle after a STOP strobe that closes an open transaction. A STOP strobe with no transaction open has no effect.
- R10: A START strobe inside an open transaction (a repeated START) does not clear what has been observed since the first START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the static-level classification |
| ad0_lvl | input | 1 | Synchronized level of the strap that sets address bits 1:0 and ports 3:0 |
| ad2_lvl | input | 1 | Synchronized level of the strap that sets address bits 3:2 and ports 7:4 |
| scl_lvl | input | 1 | Synchronized serial clock level |
| sda_lvl | input | 1 | Synchronized serial data level |
| start_stb | input | 1 | One-cycle START (or repeated START) strobe from the bus front end |
| stop_stb | input | 1 | One-cycle STOP strobe from the bus front end |
| addr_nibble | output | 4 | Decoded low nibble of the bus address |
| port_default | output | 8 | Default output-port levels, one group of four per strap |

## Verification
The straps are wired in every combination of ground, supply, clock and data, then run through real byte transfers. These show whether each strap is told apart from the others, and whether both encodings are correct for all four classes. Other patterns target the retention rules. In one, data mirrors the clock, so a bus-line strap matches both lines. In another, a strap is the inverse of the clock, so it is both high and low while differing from both lines. Together these separate "keep previous" from a wrong guess. Further patterns cover a repeated START after a write to a clock-tied strap, a stray STOP while idle, a rewired strap picked up without reset, and reset applied while straps sit on idle bus lines. A reference model compares the outputs on every cycle, so any update before the closing STOP shows up as a miscompare.

// File: rtl/adp_pkg.sv
package adp_pkg;

    // Number of address straps and width of each address field
    localparam int NUM_PINS = 2;
    localparam int FIELD_W  = 2;
    localparam int PIN_LO   = 0;   // strap for address bits 1:0, ports 3:0
    localparam int PIN_HI   = 1;   // strap for address bits 3:2, ports 7:4

    typedef enum logic [1:0] {
        CLS_GND = 2'd0,
        CLS_SUP = 2'd1,
        CLS_SCL = 2'd2,
        CLS_SDA = 2'd3
    } pin_class_e;

    // Evidence gathered over one transaction
    typedef struct packed {
        logic diff_scl;
        logic diff_sda;
        logic seen_hi;
        logic seen_lo;
    } obs_t;

    function automatic obs_t observe(input logic pin, input logic scl, input logic sda);
        obs_t o;
        o.diff_scl = pin ^ scl;
        o.diff_sda = pin ^ sda;
        o.seen_hi  = pin;
        o.seen_lo  = ~pin;
        return o;
    endfunction

    function automatic obs_t merge_obs(input obs_t a, input obs_t b);
        obs_t m;
        m.diff_scl = a.diff_scl | b.diff_scl;
        m.diff_sda = a.diff_sda | b.diff_sda;
        m.seen_hi  = a.seen_hi  | b.seen_hi;
        m.seen_lo  = a.seen_lo  | b.seen_lo;
        return m;
    endfunction

    function automatic pin_class_e static_class(input logic pin);
        return pin ? CLS_SUP : CLS_GND;
    endfunction

    function automatic pin_class_e classify(input obs_t o, input pin_class_e prev);
        pin_class_e r;
        r = prev;
        if (!o.diff_scl && !o.diff_sda) begin
            r = prev;
        end else if (!o.diff_scl) begin
            r = CLS_SCL;
        end else if (!o.diff_sda) begin
            r = CLS_SDA;
        end else if (o.seen_hi && !o.seen_lo) begin
            r = CLS_SUP;
        end else if (o.seen_lo && !o.seen_hi) begin
            r = CLS_GND;
        end
        return r;
    endfunction

    // Address field code for a strap; each strap has its own table
    function automatic logic [FIELD_W-1:0] field_code(input int idx, input pin_class_e c);
        logic [FIELD_W-1:0] v;
        if (idx == PIN_HI) begin
            case (c)
                CLS_SCL: v = 2'b00;
                CLS_SDA: v = 2'b01;
                CLS_GND: v = 2'b10;
                default: v = 2'b11;
            endcase
        end else begin
            case (c)
                CLS_GND: v = 2'b00;
                CLS_SUP: v = 2'b01;
                CLS_SCL: v = 2'b10;
                default: v = 2'b11;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/adp_txn_window.sv
module adp_txn_window (
    input  logic clk,
    input  logic rst,
    input  logic start_stb,
    input  logic stop_stb,
    output logic acc_first,
    output logic acc_en,
    output logic acc_close
);

    logic open_q;

    // A START from idle opens a window; a repeated START merely continues it
    assign acc_first = start_stb & ~open_q;
    assign acc_en    = start_stb | open_q;
    assign acc_close = stop_stb & open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (acc_close) begin
            open_q <= 1'b0;
        end else if (start_stb) begin
            open_q <= 1'b1;
        end
    end

    assert_window_opens_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(open_q) |-> $past(start_stb));

    assert_window_closes_R9: assert property (@(posedge clk) disable iff (rst)
        (open_q && stop_stb) |=> !open_q);

    assert_restart_keeps_open_R10: assert property (@(posedge clk) disable iff (rst)
        (open_q && start_stb && !stop_stb) |=> open_q);

endmodule

// File: rtl/adp_pin_tracker.sv
module adp_pin_tracker
    import adp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_lvl,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       acc_first,
    input  logic       acc_en,
    input  logic       acc_close,
    output pin_class_e cls_o
);

    obs_t       acc_q;
    obs_t       obs_now;
    obs_t       acc_next;
    pin_class_e cls_q;
    logic       closed_once_q;

    always_comb begin
        obs_now  = observe(pin_lvl, scl_lvl, sda_lvl);
        acc_next = acc_first ? obs_now : merge_obs(acc_q, obs_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (acc_en) begin
            acc_q <= acc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q         <= static_class(pin_lvl);
            closed_once_q <= 1'b0;
        end else if (acc_close) begin
            cls_q         <= classify(acc_next, cls_q);
            closed_once_q <= 1'b1;
        end
    end

    assign cls_o = cls_q;

    // Outside reset the class moves only after a closing STOP
    assert_class_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(acc_close)) |-> $stable(cls_q));

    // No bus-line class before any transaction has been closed
    assert_static_until_stop_R1: assert property (@(posedge clk) disable iff (rst)
        !closed_once_q |-> (cls_q == CLS_GND || cls_q == CLS_SUP));

endmodule

// File: rtl/adp_field_encoder.sv
module adp_field_encoder
    import adp_pkg::*;
#(
    parameter int GROUP_W = 4,
    localparam int CLS_W  = NUM_PINS * 2,
    localparam int NIB_W  = NUM_PINS * FIELD_W,
    localparam int PORT_W = NUM_PINS * GROUP_W
) (
    input  logic [CLS_W-1:0]  cls_vec,
    output logic [NIB_W-1:0]  nibble,
    output logic [PORT_W-1:0] port_default
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_field
        pin_class_e c;
        assign c = pin_class_e'(cls_vec[g*2 +: 2]);
        assign nibble[g*FIELD_W +: FIELD_W]    = field_code(g, c);
        assign port_default[g*GROUP_W +: GROUP_W] = {GROUP_W{c != CLS_GND}};
    end

endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
    import adp_pkg::*;
#(
    parameter int GROUP_W = 4,
    localparam int NIB_W  = NUM_PINS * FIELD_W,
    localparam int PORT_W = NUM_PINS * GROUP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ad0_lvl,
    input  logic              ad2_lvl,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              start_stb,
    input  logic              stop_stb,
    output logic [NIB_W-1:0]  addr_nibble,
    output logic [PORT_W-1:0] port_default
);

    logic                  acc_first;
    logic                  acc_en;
    logic                  acc_close;
    logic [NUM_PINS-1:0]   pin_vec;
    logic [NUM_PINS*2-1:0] cls_vec;

    assign pin_vec[PIN_LO] = ad0_lvl;
    assign pin_vec[PIN_HI] = ad2_lvl;

    adp_txn_window u_window (
        .clk       (clk),
        .rst       (rst),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .acc_first (acc_first),
        .acc_en    (acc_en),
        .acc_close (acc_close)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_class_e cls;
        adp_pin_tracker u_trk (
            .clk       (clk),
            .rst       (rst),
            .pin_lvl   (pin_vec[p]),
            .scl_lvl   (scl_lvl),
            .sda_lvl   (sda_lvl),
            .acc_first (acc_first),
            .acc_en    (acc_en),
            .acc_close (acc_close),
            .cls_o     (cls)
        );
        assign cls_vec[p*2 +: 2] = cls;
    end

    adp_field_encoder #(.GROUP_W(GROUP_W)) u_enc (
        .cls_vec      (cls_vec),
        .nibble       (addr_nibble),
        .port_default (port_default)
    );

    // Ground code on a field goes with an all-low port group, and only then
    assert_hi_group_matches_R4: assert property (@(posedge clk) disable iff (rst)
        (addr_nibble[PIN_HI*FIELD_W +: FIELD_W] == 2'b10) ==
        (port_default[PIN_HI*GROUP_W +: GROUP_W] == '0));

    assert_lo_group_matches_R4: assert property (@(posedge clk) disable iff (rst)
        (addr_nibble[PIN_LO*FIELD_W +: FIELD_W] == 2'b00) ==
        (port_default[PIN_LO*GROUP_W +: GROUP_W] == '0));

    assert_nibble_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stop_stb)) |-> $stable(addr_nibble));

endmodule

// File: tb/sim_addr_pin_decoder.sv
module sim_addr_pin_decoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic start_stb = 1'b0;
    logic stop_stb = 1'b0;
    logic ad0, ad2;
    logic [3:0] addr_nibble;
    logic [7:0] port_default;

    // Strap wiring: 0 ground, 1 supply, 2 clock, 3 data, 4 inverse of clock
    int mode0 = 1;
    int mode2 = 1;

    int vectors = 0;
    int fails = 0;
    string phase = "R1 reset";
    bit model_valid = 0;

    // Model state; classes use 0 ground, 1 supply, 2 clock, 3 data
    int m_cls[2];
    bit m_open = 0;
    bit m_dscl[2], m_dsda[2], m_hi[2], m_lo[2];

    always #4 clk = ~clk;

    function automatic logic wire_lvl(input int m, input logic c, input logic d);
        case (m)
            0: return 1'b0;
            1: return 1'b1;
            2: return c;
            3: return d;
            default: return ~c;
        endcase
    endfunction

    assign ad0 = wire_lvl(mode0, scl, sda);
    assign ad2 = wire_lvl(mode2, scl, sda);

    addr_pin_decoder u0 (
        .clk          (clk),
        .rst          (rst),
        .ad0_lvl      (ad0),
        .ad2_lvl      (ad2),
        .scl_lvl      (scl),
        .sda_lvl      (sda),
        .start_stb    (start_stb),
        .stop_stb     (stop_stb),
        .addr_nibble  (addr_nibble),
        .port_default (port_default)
    );

    // Reference model, updated on each rising edge
    always @(posedge clk) begin
        logic lv[2];
        lv[0] = ad0;
        lv[1] = ad2;
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                m_cls[p] = lv[p] ? 1 : 0;
                m_dscl[p] = 0; m_dsda[p] = 0; m_hi[p] = 0; m_lo[p] = 0;
            end
            m_open = 0;
            model_valid = 1;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (start_stb && !m_open) begin
                    m_dscl[p] = 0; m_dsda[p] = 0; m_hi[p] = 0; m_lo[p] = 0;
                end
                if (start_stb || m_open) begin
                    if (lv[p] != scl) m_dscl[p] = 1;
                    if (lv[p] != sda) m_dsda[p] = 1;
                    if (lv[p]) m_hi[p] = 1; else m_lo[p] = 1;
                end
                if (stop_stb && m_open) begin
                    if (!m_dscl[p] && !m_dsda[p]) ;
                    else if (!m_dscl[p]) m_cls[p] = 2;
                    else if (!m_dsda[p]) m_cls[p] = 3;
                    else if (m_hi[p] && !m_lo[p]) m_cls[p] = 1;
                    else if (m_lo[p] && !m_hi[p]) m_cls[p] = 0;
                end
            end
            if (stop_stb && m_open) m_open = 0;
            else if (start_stb) m_open = 1;
        end
    end

    function automatic logic [1:0] exp_hi(input int c);
        case (c)
            2: return 2'b00;
            3: return 2'b01;
            0: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] exp_lo(input int c);
        return 2'(c);
    endfunction

    // Compare on every falling edge
    always @(negedge clk) begin
        if (model_valid) begin
            logic [1:0] eh, el;
            logic [7:0] ed;
            eh = exp_hi(m_cls[1]);
            el = exp_lo(m_cls[0]);
            ed = {{4{m_cls[1] != 0}}, {4{m_cls[0] != 0}}};
            vectors++;
            if (addr_nibble[3:2] !== eh) begin
                fails++;
                $display("FAIL R2 (phase %s) nibble[3:2] act %b exp %b", phase, addr_nibble[3:2], eh);
            end
            if (addr_nibble[1:0] !== el) begin
                fails++;
                $display("FAIL R3 (phase %s) nibble[1:0] act %b exp %b", phase, addr_nibble[1:0], el);
            end
            if (port_default !== ed) begin
                fails++;
                $display("FAIL R4 (phase %s) port_default act %h exp %h", phase, port_default, ed);
            end
        end
    end

    task automatic step(input logic c, input logic d, input logic st, input logic sp);
        @(posedge clk);
        #1;
        scl = c; sda = d; start_stb = st; stop_stb = sp;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            step(1'b0, b[i], 1'b0, 1'b0);
            step(1'b1, b[i], 1'b0, 1'b0);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic txn(input logic [7:0] b0, input logic [7:0] b1, input bit rep);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(b0);
        if (rep) begin
            step(1'b0, 1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b1, 1'b0);
        end
        send_byte(b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    // Transaction in which data mirrors the clock throughout
    task automatic txn_mirror();
        step(1'b1, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0);
            step(1'b1, 1'b1, 1'b0, 1'b0);
        end
        step(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        @(posedge clk); #1;
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        // R1: straps on idle bus lines read as supply under reset
        phase = "R1 reset bus-tied";
        mode0 = 3; mode2 = 2;
        do_reset();
        phase = "R1 reset ground";
        mode0 = 0; mode2 = 0;
        do_reset();
        phase = "R1 reset mixed";
        mode0 = 1; mode2 = 0;
        do_reset();

        // R5/R6 with every encoding; R2/R3/R4 across all classes
        phase = "R5 R6 clock and data";
        mode0 = 2; mode2 = 3; txn(8'hA5, 8'h3C, 0);
        mode0 = 3; mode2 = 2; txn(8'h96, 8'h0F, 0);
        phase = "R7 static levels";
        mode0 = 0; mode2 = 1; txn(8'h5A, 8'hC3, 0);
        mode0 = 1; mode2 = 0; txn(8'h71, 8'h8E, 0);
        phase = "R2 R3 R4 sweep";
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                mode2 = a; mode0 = b;
                txn(8'hB4, 8'h2D, 0);
            end
        end

        // R8: data mirrors clock, bus-tied straps match both lines
        phase = "R8 mirror keeps";
        mode0 = 3; mode2 = 2; txn(8'hA5, 8'h5A, 0);
        mode0 = 2; mode2 = 3; txn_mirror();
        mode0 = 1; mode2 = 0; txn_mirror();

        // R7: strap both high and low while differing from both lines
        phase = "R7 mixed keeps";
        mode0 = 2; mode2 = 1; txn(8'hC6, 8'h39, 0);
        mode0 = 4; mode2 = 4; txn(8'hC6, 8'h39, 0);

        // R10: repeated START between the two bytes
        phase = "R10 repeated start";
        mode0 = 2; mode2 = 3; txn(8'hE1, 8'h1E, 1);
        mode0 = 3; mode2 = 2; txn(8'h00, 8'hFF, 1);

        // R9: stray STOP while idle changes nothing
        phase = "R9 stray stop";
        mode0 = 0; mode2 = 1;
        step(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        phase = "R9 rewire then decode";
        txn(8'h69, 8'h96, 0);

        phase = "R1 reset after decode";
        mode0 = 2; mode2 = 3;
        do_reset();
        step(1'b1, 1'b1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in phase %s: act hung exp finished", phase);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule